// File: doc/BRIEF.md
# Paged Fly-By DMA Channel Engine

This block moves bytes between peripherals and memory on a small 8-bit system bus without the processor touching each byte. It has four channels. Each one keeps a 16-bit address counter, a 16-bit transfer counter and a 4-bit page value that together drive a 20-bit bus address. A peripheral asks for service by raising its request line and is answered by its own acknowledge line. For a transfer between an I/O port and memory, the engine issues one bus cycle: it drives the address and both strobes, and the data passes straight from source to destination without entering the engine. A software-started memory-to-memory copy runs in two cycles through an 8-bit holding register.

Software sets up each channel through a simple write port. It selects a channel and a field and then writes a value. The page value never takes part in counting, so a run of transfers wraps around inside its 64 KiB page. When a channel's transfer counter runs out, the engine flags terminal count and then either reloads the channel's starting values or masks the channel. A single-transfer mode and a demand (burst) mode decide how long a channel keeps the bus.

Top module: `dma_fly_engine`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into field `wr_sel` of channel `wr_ch` at the clock edge. The fields are: 0 start address (loads both the reload copy and the live counter), 1 transfer count (loads both copies), 2 page, 3 mode, 4 mask (bit 0), 5 memory-to-memory start (bit 0, not tied to a channel). Mode bits: bit 0 = count address down, bit 1 = demand mode, bit 2 = reload on terminal count, bit 3 = memory-to-I/O direction. After reset every channel is masked and every counter is zero.
- R2: During a channel's transfer, `bus_addr` equals {page, address counter}. The page never changes because of a transfer, so an increment from 0xFFFF goes to 0x0000 within the same page.
- R3: After each transfer the address counter steps by one. It counts up when mode bit 0 is clear and down when it is set.
- R4: A count value of N-1 gives N transfers. `tc` is high during the transfer in which the counter is zero, and that transfer rolls the counter over to all-ones.
- R5: Among unmasked requests, the lowest-numbered channel is granted. At most one `dack` bit is high at any time.
- R6: A request is granted only if DREQ is high when the engine is idle at a clock edge. `dack` then rises at that edge. A request that is dropped before this point is never serviced and leaves the channel's address unchanged.
- R7: In single mode a channel makes one transfer per grant, and then there is at least one cycle with every `dack` low, even if DREQ stays high.
- R8: In demand mode `dack` stays high for transfer after transfer. The burst ends after the transfer during which TC occurs, `eop` is high, or the channel's DREQ is low.
- R9: A fly-by transfer asserts `io_rd` and `mem_wr` when mode bit 3 is clear, or `mem_rd` and `io_wr` when it is set. `wdata_en` stays low throughout.
- R10: A masked channel's DREQ is ignored. Terminal count with reload off sets the channel's mask, and this holds even when `eop` is high in the same cycle.
- R11: Terminal count with reload on restores the start address and the count, and leaves the channel unmasked.
- R12: Once started, a memory-to-memory copy repeats pairs of cycles. The first cycle reads at channel 0's {page, address} with `mem_rd`. The second writes the captured byte on `wdata` with `mem_wr` and `wdata_en` at channel 1's {page, address}. Both addresses step, and channel 1's counter sets the length and `tc`. Terminal count or `eop` stops the copy. Unmasked DREQs are served before the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel selected for the write |
| wr_sel | input | 3 | Field selected for the write |
| wr_data | input | 16 | Write value |
| dreq | input | 4 | Per-channel service requests |
| eop | input | 1 | External end-of-process |
| mem_rdata | input | 8 | Memory read data (used only by the copy) |
| dack | output | 4 | Per-channel acknowledges |
| tc | output | 1 | Terminal count of the current transfer |
| bus_addr | output | 20 | Bus address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| wdata | output | 8 | Holding register contents |
| wdata_en | output | 1 | Engine drives `wdata` onto the bus |

## Verification
Two things can land on the same transfer cycle: terminal count, and an end condition from outside (`eop` high, or DREQ dropped). The bench times an `eop` pulse and a DREQ drop so that they coincide with the last transfer of a demand burst. It then checks that `tc` still shows, that the burst stops, and that the channel ends up masked, because terminal count still applies. The bench also raises two requests in the same idle cycle and checks which one is granted. It withdraws the losing request during the winner's transfer and checks that the loser is never serviced.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FLY,
        ST_MRD,
        ST_MWR
    } seq_e;

    localparam logic [2:0] F_ADDR  = 3'd0;
    localparam logic [2:0] F_COUNT = 3'd1;
    localparam logic [2:0] F_PAGE  = 3'd2;
    localparam logic [2:0] F_MODE  = 3'd3;
    localparam logic [2:0] F_MASK  = 3'd4;
    localparam logic [2:0] F_M2M   = 3'd5;

    typedef struct packed {
        logic to_io;
        logic autoinit;
        logic demand;
        logic dec;
    } mode_t;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int PW = 4,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic [2:0]    wr_sel,
    input  logic [WW-1:0] wr_data,
    input  logic          step_addr,
    input  logic          step_cnt,
    output logic [AW-1:0] addr,
    output logic [PW-1:0] page,
    output mode_t         mode,
    output logic          masked,
    output logic          cnt_zero
);

    logic [AW-1:0] base_a, cur_a;
    logic [CW-1:0] base_c, cur_c;
    logic [PW-1:0] page_q;
    mode_t         mode_q;
    logic          mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_a <= '0;
            cur_a  <= '0;
            base_c <= '0;
            cur_c  <= '0;
            page_q <= '0;
            mode_q <= '0;
            mask_q <= 1'b1;
        end else if (wr_hit) begin
            case (wr_sel)
                F_ADDR:  begin base_a <= wr_data[AW-1:0]; cur_a <= wr_data[AW-1:0]; end
                F_COUNT: begin base_c <= wr_data[CW-1:0]; cur_c <= wr_data[CW-1:0]; end
                F_PAGE:  page_q <= wr_data[PW-1:0];
                F_MODE:  mode_q <= mode_t'(wr_data[3:0]);
                F_MASK:  mask_q <= wr_data[0];
                default: ;
            endcase
        end else begin
            if (step_addr)
                cur_a <= mode_q.dec ? cur_a - 1'b1 : cur_a + 1'b1;
            if (step_cnt) begin
                if (cur_c == '0) begin
                    if (mode_q.autoinit) begin
                        cur_a <= base_a;
                        cur_c <= base_c;
                    end else begin
                        cur_c  <= '1;
                        mask_q <= 1'b1;
                    end
                end else begin
                    cur_c <= cur_c - 1'b1;
                end
            end
        end
    end

    assign addr     = cur_a;
    assign page     = page_q;
    assign mode     = mode_q;
    assign masked   = mask_q;
    assign cnt_zero = (cur_c == '0);

    // R2: page is untouched by transfers
    a_r2_page_fixed: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(page_q));

    // R4: counter decrements by one when not at zero
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (step_cnt && !wr_hit && cur_c != '0) |=> (cur_c == $past(cur_c) - 1'b1));

    // R10: terminal count without reload masks the channel
    a_r10_mask_on_tc: assert property (@(posedge clk) disable iff (rst)
        (step_cnt && !wr_hit && cur_c == '0 && !mode_q.autoinit) |=> mask_q);

    // R11: terminal count with reload restores the count
    a_r11_reload: assert property (@(posedge clk) disable iff (rst)
        (step_cnt && !wr_hit && cur_c == '0 && mode_q.autoinit) |=> (cur_c == base_c));

endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/dma_fly_engine.sv
module dma_fly_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int PW  = 4,
    parameter int DW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int WW  = (AW > CW) ? AW : CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [2:0]        wr_sel,
    input  logic [WW-1:0]     wr_data,
    input  logic [NCH-1:0]    dreq,
    input  logic              eop,
    input  logic [DW-1:0]     mem_rdata,
    output logic [NCH-1:0]    dack,
    output logic              tc,
    output logic [PW+AW-1:0]  bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DW-1:0]     wdata,
    output logic              wdata_en
);

    seq_e           st;
    logic [CHW-1:0] act;
    logic           m2m_go;
    logic [DW-1:0]  hold;

    logic [AW-1:0]  ch_addr [NCH];
    logic [PW-1:0]  ch_page [NCH];
    mode_t          ch_mode [NCH];
    logic [NCH-1:0] ch_mask, ch_zero, hit, st_a, st_c;

    logic [NCH-1:0] pend;
    logic           gnt_any;
    logic [CHW-1:0] gnt_idx;
    mode_t          am;
    logic           burst_end;

    assign pend = dreq & ~ch_mask;

    dma_prio #(.N(NCH), .IW(CHW)) u_prio (
        .req (pend),
        .any (gnt_any),
        .idx (gnt_idx)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign hit[g]  = wr_en && (wr_ch == CHW'(g));
        assign st_a[g] = (st == ST_FLY && act == CHW'(g))
                       || (st == ST_MRD && g == 0)
                       || (st == ST_MWR && g == 1);
        assign st_c[g] = (st == ST_FLY && act == CHW'(g))
                       || (st == ST_MWR && g == 1);

        dma_chan #(.AW(AW), .CW(CW), .PW(PW), .WW(WW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (hit[g]),
            .wr_sel    (wr_sel),
            .wr_data   (wr_data),
            .step_addr (st_a[g]),
            .step_cnt  (st_c[g]),
            .addr      (ch_addr[g]),
            .page      (ch_page[g]),
            .mode      (ch_mode[g]),
            .masked    (ch_mask[g]),
            .cnt_zero  (ch_zero[g])
        );
    end

    assign am        = ch_mode[act];
    assign burst_end = ch_zero[act] || eop || !am.demand || !dreq[act];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            act    <= '0;
            m2m_go <= 1'b0;
            hold   <= '0;
        end else begin
            if (wr_en && wr_sel == F_M2M) m2m_go <= wr_data[0];
            case (st)
                ST_IDLE: begin
                    if (gnt_any) begin
                        st  <= ST_FLY;
                        act <= gnt_idx;
                    end else if (m2m_go) begin
                        st <= ST_MRD;
                    end
                end
                ST_FLY: if (burst_end) st <= ST_IDLE;
                ST_MRD: begin
                    hold <= mem_rdata;
                    st   <= ST_MWR;
                end
                ST_MWR: begin
                    st <= ST_IDLE;
                    if (ch_zero[1] || eop) m2m_go <= 1'b0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dack     = '0;
        tc       = 1'b0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        wdata_en = 1'b0;
        wdata    = hold;
        bus_addr = {ch_page[act], ch_addr[act]};
        case (st)
            ST_FLY: begin
                dack[act] = 1'b1;
                tc        = ch_zero[act];
                if (am.to_io) begin
                    mem_rd = 1'b1;
                    io_wr  = 1'b1;
                end else begin
                    io_rd  = 1'b1;
                    mem_wr = 1'b1;
                end
            end
            ST_MRD: begin
                bus_addr = {ch_page[0], ch_addr[0]};
                mem_rd   = 1'b1;
            end
            ST_MWR: begin
                bus_addr = {ch_page[1], ch_addr[1]};
                mem_wr   = 1'b1;
                wdata_en = 1'b1;
                tc       = ch_zero[1];
            end
            default: ;
        endcase
    end

    // R5: one acknowledge at most
    a_r5_one_dack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R5: channel 0 wins from idle
    a_r5_ch0_first: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && pend[0]) |=> dack[0]);

    // R6: an acknowledge always follows a request seen one cycle earlier
    a_r6_dack_has_req: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> (|($past(dreq) & dack)));

    // R7: single mode releases after one transfer
    a_r7_single_release: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && !am.demand) |=> (dack == '0));

    // R8: terminal count ends a burst
    a_r8_tc_ends: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && tc) |=> (dack == '0));

    // R9: fly-by cycles never drive data
    a_r9_flyby_no_data: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> (!wdata_en && (mem_rd != mem_wr) && (io_rd != io_wr)));

    // R12: the write step carries the byte read one cycle earlier
    a_r12_copy_byte: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && dack == '0) |=> (wdata_en && mem_wr && wdata == $past(mem_rdata)));

endmodule

// File: tb/dma_fly_engine_test.sv
module dma_fly_engine_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_ch;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic [3:0]  dreq;
    logic        eop;
    logic [7:0]  mem_rdata;
    logic [3:0]  dack;
    logic        tc;
    logic [19:0] bus_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [7:0]  wdata;
    logic        wdata_en;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign mem_rdata = bus_addr[7:0] ^ 8'h5A;

    dma_fly_engine uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .dreq(dreq), .eop(eop), .mem_rdata(mem_rdata),
        .dack(dack), .tc(tc), .bus_addr(bus_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .wdata(wdata),
        .wdata_en(wdata_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic prog(input logic [1:0] ch, input logic [2:0] sel, input logic [15:0] val);
        wr_en = 1'b1; wr_ch = ch; wr_sel = sel; wr_data = val;
        tick;
        wr_en = 1'b0;
    endtask

    task automatic wait_dack(input int ch);
        for (int i = 0; i < 20; i++) begin
            if (dack[ch]) break;
            tick;
        end
        chk(dack[ch], "R6 grant arrives", 32'(dack), 32'(1 << ch));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_ch = 0; wr_sel = 0; wr_data = 0; dreq = 0; eop = 0;
        repeat (3) tick;
        rst = 1'b0;
        tick;

        // R1 reset state: quiet outputs, all channels masked
        chk(dack == 0 && !tc && !mem_rd && !mem_wr && !io_rd && !io_wr && !wdata_en,
            "R1 reset outputs", {dack, tc, mem_rd, mem_wr, io_rd, io_wr, wdata_en}, 0);
        dreq = 4'b1111;
        repeat (4) begin
            tick;
            chk(dack == 0, "R10 masked after reset", 32'(dack), 0);
        end
        dreq = 0;
        tick;

        // Channel 2: single mode, up count, wrap within page
        prog(2, 3'd0, 16'hFFFE);
        prog(2, 3'd1, 16'd2);
        prog(2, 3'd2, 16'h5);
        prog(2, 3'd3, 16'h0);
        prog(2, 3'd4, 16'h0);
        dreq[2] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            logic [15:0] ea;
            wait_dack(2);
            ea = 16'hFFFE + 16'(k);
            chk(bus_addr == {4'h5, ea}, "R1 R2 page wrap address", 32'(bus_addr), 32'({4'h5, ea}));
            chk(io_rd && mem_wr && !mem_rd && !io_wr && !wdata_en, "R9 io-to-memory strobes",
                {io_rd, mem_wr, mem_rd, io_wr, wdata_en}, 5'b11000);
            chk(tc == (k == 2), "R4 terminal count timing", 32'(tc), 32'(k == 2));
            tick;
            chk(dack == 0, "R7 single mode release", 32'(dack), 0);
        end
        repeat (5) begin
            tick;
            chk(dack == 0, "R10 mask set on terminal count", 32'(dack), 0);
        end
        dreq[2] = 1'b0;

        // Channel 3: demand, down count, memory-to-io
        prog(3, 3'd0, 16'h0010);
        prog(3, 3'd1, 16'd9);
        prog(3, 3'd2, 16'hA);
        prog(3, 3'd3, 16'b1011);
        prog(3, 3'd4, 16'h0);
        dreq[3] = 1'b1;
        wait_dack(3);
        for (int n = 0; n < 4; n++) begin
            logic [15:0] ea;
            ea = 16'h0010 - 16'(n);
            chk(dack == 4'b1000, "R8 demand burst continues", 32'(dack), 32'h8);
            chk(bus_addr == {4'hA, ea}, "R3 down-count address", 32'(bus_addr), 32'({4'hA, ea}));
            chk(mem_rd && io_wr && !io_rd && !mem_wr, "R9 memory-to-io strobes",
                {mem_rd, io_wr, io_rd, mem_wr}, 4'b1100);
            if (n == 3) dreq[3] = 1'b0;
            tick;
        end
        chk(dack == 0, "R8 burst ends on dropped request", 32'(dack), 0);
        tick;
        chk(dack == 0, "R6 no grant without request", 32'(dack), 0);
        dreq[3] = 1'b1;
        wait_dack(3);
        chk(bus_addr == {4'hA, 16'h000C}, "R3 address resumes", 32'(bus_addr), 32'({4'hA, 16'h000C}));
        eop = 1'b1;
        tick;
        eop = 1'b0;
        chk(dack == 0, "R8 burst ends on eop", 32'(dack), 0);
        wait_dack(3);
        for (int n = 5; n < 10; n++) begin
            logic [15:0] ea;
            ea = 16'h0010 - 16'(n);
            chk(dack == 4'b1000 && bus_addr == {4'hA, ea}, "R8 demand run to terminal count",
                32'(bus_addr), 32'({4'hA, ea}));
            chk(tc == (n == 9), "R4 terminal count in burst", 32'(tc), 32'(n == 9));
            if (n == 9) eop = 1'b1;
            tick;
        end
        eop = 1'b0;
        chk(dack == 0, "R8 burst ends on terminal count with eop", 32'(dack), 0);
        repeat (4) begin
            tick;
            chk(dack == 0, "R10 mask wins over coincident eop", 32'(dack), 0);
        end
        dreq[3] = 1'b0;

        // Priority and withdrawn request
        prog(0, 3'd0, 16'h0400);
        prog(0, 3'd1, 16'h00FF);
        prog(0, 3'd2, 16'h0);
        prog(0, 3'd3, 16'h0);
        prog(0, 3'd4, 16'h0);
        prog(1, 3'd0, 16'h0100);
        prog(1, 3'd1, 16'd1);
        prog(1, 3'd2, 16'h1);
        prog(1, 3'd3, 16'b0100);
        prog(1, 3'd4, 16'h0);
        dreq = 4'b0011;
        tick;
        chk(dack == 4'b0001, "R5 lowest channel wins", 32'(dack), 1);
        dreq[1] = 1'b0;
        tick;
        chk(dack == 0, "R7 release between grants", 32'(dack), 0);
        tick;
        chk(dack == 4'b0001, "R5 channel 0 regranted", 32'(dack), 1);
        dreq[0] = 1'b0;
        repeat (4) begin
            tick;
            chk(dack == 0, "R6 withdrawn request not served", 32'(dack), 0);
        end

        // Channel 1 reload on terminal count
        dreq[1] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            logic [15:0] ea;
            wait_dack(1);
            ea = 16'h0100 + 16'(k % 2);
            chk(bus_addr == {4'h1, ea}, "R11 R6 reload address sequence", 32'(bus_addr), 32'({4'h1, ea}));
            chk(tc == (k == 1), "R4 R11 terminal count", 32'(tc), 32'(k == 1));
            tick;
        end
        wait_dack(1);
        chk(dack == 4'b0010, "R11 channel stays unmasked", 32'(dack), 2);
        dreq[1] = 1'b0;
        tick; tick;

        // Memory-to-memory copy
        prog(0, 3'd0, 16'h2000);
        prog(0, 3'd2, 16'h3);
        prog(0, 3'd3, 16'h0);
        prog(1, 3'd0, 16'h3000);
        prog(1, 3'd1, 16'd2);
        prog(1, 3'd2, 16'h4);
        prog(1, 3'd3, 16'h0);
        prog(0, 3'd5, 16'h1);
        for (int k = 0; k < 3; k++) begin
            logic [15:0] sa, da;
            for (int i = 0; i < 20; i++) begin
                if (mem_rd) break;
                tick;
            end
            sa = 16'h2000 + 16'(k);
            da = 16'h3000 + 16'(k);
            chk(mem_rd && !wdata_en && dack == 0 && bus_addr == {4'h3, sa}, "R12 copy read cycle",
                32'(bus_addr), 32'({4'h3, sa}));
            tick;
            chk(mem_wr && wdata_en && bus_addr == {4'h4, da}, "R12 copy write cycle",
                32'(bus_addr), 32'({4'h4, da}));
            chk(wdata == (8'(k) ^ 8'h5A), "R12 copied byte", 32'(wdata), 32'(8'(k) ^ 8'h5A));
            chk(tc == (k == 2), "R12 copy terminal count", 32'(tc), 32'(k == 2));
            tick;
        end
        repeat (6) begin
            tick;
            chk(!mem_rd && !mem_wr, "R12 copy stops after terminal count", {mem_rd, mem_wr}, 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule